// File: doc/BRIEF.md
# Software-Triggered Interrupt Port

This block is a tiny slave in I/O space that occupies a 32-byte window. An external decoder compares the upper address bits with the window base. It then raises `win_en` and passes the low five bits of the offset in on `ofs`. The block answers byte reads with four fixed identification bytes and with the interrupt line and pin codes, which it receives as inputs. It also holds a single pending flag that drives a level interrupt output.

Software raises the interrupt by writing any value to offset 6. It collects and clears the interrupt by reading the same offset, which returns 1 if the flag was pending. The read is destructive, so a handler reads offset 6 once and learns whether this port was the source. Wider bus accesses act as byte accesses. Only the low byte of write data counts, and read data is zero-extended to the bus width.

Top module: `swirq_port`

## Requirements
- R1: After reset `irq_out` is low and a read of offset 6 returns 0.
- R2: Reads at offsets 0, 1, 2 and 3 return 0x1A, 0x07, 0x0B and 0xAB respectively.
- R3: A read at offset 4 returns `irq_line`, and a read at offset 5 returns `irq_pin`, both as they are in the cycle of the read.
- R4: A read at offset 6 returns the pending flag in bit 0 (0 or 1). If the flag was set, `irq_out` is low from the cycle after the read strobe.
- R5: A write of any data to offset 6 while the flag is clear makes `irq_out` high from the cycle after the write strobe.
- R6: A write to offset 6 while the flag is set has no effect: one later read still returns 1, and the read after that returns 0.
- R7: Reads at offsets 7 to 31 return 0, and writes to any offset other than 6 leave `irq_out` unchanged.
- R8: Bits 31:8 of `rd_data` are always 0, and bits 31:8 of `wr_data` never affect the block.
- R9: While `win_en` is low, `rd_data` is 0 and neither strobe changes `irq_out`.
- R10: `rd_data` is 0 in any cycle without `rd_stb`. Each cycle in which `rd_stb` is high at offset 6 counts as exactly one read.
- R11: If a read and a write to offset 6 fall in the same cycle, the read returns the old flag. A set flag is cleared and the write is dropped. A clear flag is set by the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Window selected by the external base decoder |
| ofs | input | 5 | Byte offset within the window |
| rd_stb | input | 1 | Read strobe, one access per high cycle |
| wr_stb | input | 1 | Write strobe, one access per high cycle |
| wr_data | input | 32 | Write data, only bits 7:0 used |
| irq_line | input | 8 | Interrupt line code returned at offset 4 |
| irq_pin | input | 8 | Interrupt pin code returned at offset 5 |
| rd_data | output | 32 | Combinational read data, zero-extended byte |
| irq_out | output | 1 | Registered level interrupt |

## Verification
The assertions assume that `win_en`, `ofs` and the strobes are stable across the clock edge. They also assume that a strobe marks one access per cycle, with no holding by the bus. The bench drives every input on the falling edge and samples `rd_data` shortly after that. It samples `irq_out` on the falling edge that follows the strobe's rising edge, so each access lasts exactly one cycle. Simultaneous read and write strobes are applied only at offset 6, where R11 defines the outcome.

// File: rtl/swirq_port.sv
module swirq_port #(
  parameter int OFS_W  = 5,
  parameter int BUS_W  = 32,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] ID_B0 = 8'h1A,
  parameter logic [BYTE_W-1:0] ID_B1 = 8'h07,
  parameter logic [BYTE_W-1:0] ID_B2 = 8'h0B,
  parameter logic [BYTE_W-1:0] ID_B3 = 8'hAB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [BYTE_W-1:0] irq_line,
  input  logic [BYTE_W-1:0] irq_pin,
  output logic [BUS_W-1:0]  rd_data,
  output logic              irq_out
);
  localparam logic [OFS_W-1:0] OFS_LINE = OFS_W'(4);
  localparam logic [OFS_W-1:0] OFS_PIN  = OFS_W'(5);
  localparam logic [OFS_W-1:0] OFS_TRIG = OFS_W'(6);
  localparam int PAD_W = BUS_W - BYTE_W;

  logic              pend;
  logic              rd_go, wr_go, rd_trig, wr_trig;
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] wr_byte;

  assign rd_go   = win_en && rd_stb;
  assign wr_go   = win_en && wr_stb;
  assign rd_trig = rd_go && (ofs == OFS_TRIG);
  assign wr_trig = wr_go && (ofs == OFS_TRIG);
  assign wr_byte = wr_data[BYTE_W-1:0];

  always_comb begin
    rd_byte = '0;
    unique case (ofs)
      OFS_W'(0): rd_byte = ID_B0;
      OFS_W'(1): rd_byte = ID_B1;
      OFS_W'(2): rd_byte = ID_B2;
      OFS_W'(3): rd_byte = ID_B3;
      OFS_LINE:  rd_byte = irq_line;
      OFS_PIN:   rd_byte = irq_pin;
      OFS_TRIG:  rd_byte = BYTE_W'(pend);
      default:   rd_byte = '0;
    endcase
  end

  assign rd_data = rd_go ? {{PAD_W{1'b0}}, rd_byte} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (pend)
      pend <= !rd_trig;
    else
      pend <= wr_trig;
  end

  assign irq_out = pend;

  logic unused_ok;
  assign unused_ok = ^wr_byte ^ ^wr_data[BUS_W-1:BYTE_W];

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_trig && irq_out) |=> !irq_out);
  a_r5_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_trig && !irq_out) |=> irq_out);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_trig || wr_trig) |=> $stable(irq_out));
  a_r9_window_off: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> (rd_data == '0) ##1 $stable(irq_out));
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:BYTE_W] == '0);
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> rd_data == '0);
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_trig && wr_trig && irq_out) |=> !irq_out);
endmodule

// File: tb/swirq_port_bench.sv
module swirq_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_en = 1'b0;
  logic [4:0]  ofs = '0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  irq_line = 8'h0B;
  logic [7:0]  irq_pin = 8'h04;
  logic [31:0] rd_data;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  swirq_port u_swirq_port (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .ofs(ofs),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .irq_line(irq_line), .irq_pin(irq_pin),
    .rd_data(rd_data), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int o, input bit p);
    case (o)
      0: return 32'h1A;
      1: return 32'h07;
      2: return 32'h0B;
      3: return 32'hAB;
      4: return {24'h0, irq_line};
      5: return {24'h0, irq_pin};
      6: return {31'h0, p};
      default: return 32'h0;
    endcase
  endfunction

  task automatic access(input bit en, input int o, input bit rd, input bit wr,
                        input logic [31:0] wd, output logic [31:0] got);
    @(negedge clk);
    win_en = en; ofs = 5'(o); rd_stb = rd; wr_stb = wr; wr_data = wd;
    #2 got = rd_data;
    @(negedge clk);
    win_en = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
  endtask

  initial begin
    logic [31:0] got;
    bit p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'h0, irq_out}, 0);
    access(1, 6, 1, 0, 0, got);
    chk("R1", got, 0);

    for (int k = 0; k < 4; k++) begin
      irq_line = 8'(k * 37 + 5);
      irq_pin  = 8'(k + 1);
      for (int o = 0; o < 32; o++) begin
        access(1, o, 1, 0, 0, got);
        chk(o < 4 ? "R2" : (o < 6 ? "R3" : (o == 6 ? "R4" : "R7")), got, model(o, 1'b0));
        chk("R8", {8'h0, got[31:8]}, 0);
      end
    end

    for (int o = 0; o < 32; o++) begin
      if (o == 6) continue;
      access(1, o, 0, 1, 32'hFFFF_FFFF, got);
      chk("R7", {31'h0, irq_out}, 0);
    end

    access(1, 6, 0, 1, 32'h0000_0000, got);
    chk("R5", {31'h0, irq_out}, 1);
    access(1, 6, 0, 1, 32'h1234_5600, got);
    chk("R6", {31'h0, irq_out}, 1);
    for (int o = 0; o < 32; o++) begin
      if (o == 6) continue;
      access(1, o, 0, 1, 32'h0, got);
      access(1, o, 1, 0, 0, got);
      chk("R7", {31'h0, irq_out}, 1);
    end
    access(1, 6, 1, 0, 0, got);
    chk("R6", got, 1);
    chk("R4", {31'h0, irq_out}, 0);
    access(1, 6, 1, 0, 0, got);
    chk("R6", got, 0);

    access(0, 6, 0, 1, 32'h1, got);
    chk("R9", {31'h0, irq_out}, 0);
    access(1, 6, 0, 1, 32'hFF00_0000, got);
    chk("R8", {31'h0, irq_out}, 1);
    for (int o = 0; o < 32; o++) begin
      access(0, o, 1, 0, 0, got);
      chk("R9", got, 0);
    end
    chk("R9", {31'h0, irq_out}, 1);

    @(negedge clk);
    win_en = 1'b1; ofs = 5'd6; rd_stb = 1'b0;
    #2 chk("R10", rd_data, 0);
    @(negedge clk);
    win_en = 1'b0;
    chk("R10", {31'h0, irq_out}, 1);

    @(negedge clk);
    win_en = 1'b1; ofs = 5'd6; rd_stb = 1'b1;
    #2 chk("R10", rd_data, 1);
    @(negedge clk);
    #2 chk("R10", rd_data, 0);
    @(negedge clk);
    #2 chk("R10", rd_data, 0);
    rd_stb = 1'b0; win_en = 1'b0;

    access(1, 6, 1, 1, 32'h1, got);
    chk("R11", got, 0);
    chk("R11", {31'h0, irq_out}, 1);
    access(1, 6, 1, 1, 32'h1, got);
    chk("R11", got, 1);
    chk("R11", {31'h0, irq_out}, 0);

    p = 1'b0;
    for (int n = 0; n < 40; n++) begin
      bit w = (n % 3) != 1;
      bit r = (n % 5) < 2;
      access(1, 6, r, w, 32'(n), got);
      if (r) chk("R11", got, {31'h0, p});
      p = p ? !r : w;
      chk("R11", {31'h0, irq_out}, {31'h0, p});
    end

    access(1, 6, 0, 1, 0, got);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'h0, irq_out}, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule